// File: doc/BRIEF.md
# Sixteen-point in-place FFT engine

This block computes a 16-point complex discrete Fourier transform with the radix-2 decimation-in-time method. Samples are 16-bit two's complement values in Q1.15 format. All sixteen samples sit in an internal register file. One butterfly unit is reused for every pass, and it works in place on that storage. The host first loads samples through a write port, then pulses `start`. The block runs four stages of eight butterflies at one butterfly per clock. It then pulses `done`, and the host reads the spectrum back in natural bin order through a combinational read port.

Every value that passes between stages stays at 16 bits. Each butterfly output is halved, rounded to the nearest value with ties going to even, and clipped to the 16-bit range. The result therefore equals the exact DFT scaled by 1/16, apart from rounding and clipping error. The twiddle factors W16^k for k = 0..7 come from a constant table inside the block.

The controller is a three-state machine:
- ST_IDLE accepts sample writes and waits. It takes the transition *launch* to ST_CALC when `start` is high.
- ST_CALC runs one butterfly per cycle from a 5-bit step counter. It takes the transition *finish* to ST_DONE after step 31.
- ST_DONE lasts one cycle. It always takes the transition *retire* back to ST_IDLE.

Top module: `fft16_core`

## Requirements
- R1: While reset is asserted and after it is released, `busy` and `done` are 0 and every storage location reads (0, 0).
- R2: A write (`wr_en` high at a clock edge in ST_IDLE) stores sample n = `wr_addr` at the location whose 4-bit address is n with its bits reversed (n = b3b2b1b0 goes to b0b1b2b3). Before `start`, the read port shows the sample at that location.
- R3: A `start` sampled high in ST_IDLE raises `busy` in the next cycle, and `busy` then stays high for exactly 32 consecutive cycles.
- R4: `done` is high for exactly one cycle, the cycle right after the last busy cycle. `busy` and `done` are never high together, and the block is idle in the following cycle.
- R5: `start` sampled while busy or done changes neither the timing of the running transform nor its results.
- R6: `wr_en` sampled while busy or done stores nothing.
- R7: After `done`, location k holds bin X[k] in natural order. Stage s (s = 0..3) pairs location t with location t + 2^s, for every t whose bit s is 0. It uses twiddle index (t mod 2^s)·2^(3−s). It writes round((a + b·W)/2) to t and round((a − b·W)/2) to t + 2^s. The result is the DFT scaled by 1/16.
- R8: The twiddle table holds (real, imaginary) Q1.15 values W16^k as follows. k0 = (32767, 0); k1 = (30274, −12540); k2 = (23170, −23170); k3 = (12540, −30274); k4 = (0, −32767); k5 = (−12540, −30274); k6 = (−23170, −23170); k7 = (−30274, −12540).
- R9: Each butterfly output drops 16 fractional bits of the full-precision sum: one bit for the halving and 15 for the Q1.15 product. It rounds to nearest, with an exact half going to the even neighbour.
- R10: A rounded butterfly output above 32767 is stored as 32767, and one below −32768 is stored as −32768.
- R11: `rd_re`/`rd_im` show the location selected by `rd_addr` without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Sample write strobe, honoured only in ST_IDLE |
| wr_addr | input | 4 | Natural-order sample index for the write |
| wr_re | input | 16 | Real part of the sample, Q1.15 |
| wr_im | input | 16 | Imaginary part of the sample, Q1.15 |
| start | input | 1 | Begins a transform when sampled high in ST_IDLE |
| rd_addr | input | 4 | Storage location to read; bin index after completion |
| rd_re | output | 16 | Real part of the selected location |
| rd_im | output | 16 | Imaginary part of the selected location |
| busy | output | 1 | High while butterflies are being computed |
| done | output | 1 | One-cycle completion pulse |

## Verification
The timing assertions take for granted that `start` is a synchronous level sampled at every rising edge. They also assume reset is asserted from time zero, so the state machine never begins outside ST_IDLE. They place no limit on how often `start` is raised, and they require the same 32-cycle busy window even when `start` is held high or repeated mid-run. The stimulus changes every input one time unit after a rising edge, so each edge sees settled values. It deliberately raises `start` and `wr_en` inside the busy window and in the done cycle, so that the ignored cases really reach the controller.

// File: rtl/fft16_pkg.sv
package fft16_pkg;

    localparam int N_PTS    = 16;
    localparam int ADDR_W   = $clog2(N_PTS);
    localparam int N_STAGES = ADDR_W;
    localparam int HALF_PTS = N_PTS / 2;
    localparam int BFLY_W   = $clog2(HALF_PTS);
    localparam int STAGE_W  = $clog2(N_STAGES);
    localparam int N_STEPS  = N_STAGES * HALF_PTS;
    localparam int STEP_W   = $clog2(N_STEPS);
    localparam int DATA_W   = 16;
    localparam int TW_W     = 16;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CALC = 2'd1,
        ST_DONE = 2'd2
    } fft_state_e;

endpackage

// File: rtl/fft16_addr_gen.sv
// Maps (stage, butterfly number) to the pair of storage locations and
// the twiddle index used by that butterfly.
module fft16_addr_gen
    import fft16_pkg::*;
(
    input  logic [STAGE_W-1:0] stage,
    input  logic [BFLY_W-1:0]  bfly,
    output logic [ADDR_W-1:0]  top_a,
    output logic [ADDR_W-1:0]  bot_a,
    output logic [BFLY_W-1:0]  tw_idx
);

    logic [ADDR_W-1:0]  span;
    logic [ADDR_W-1:0]  pos;
    logic [ADDR_W-1:0]  grp;
    logic [ADDR_W-1:0]  b_ext;
    logic [ADDR_W-1:0]  tw_wide;
    logic [STAGE_W:0]   grp_shift;
    logic [STAGE_W-1:0] tw_shift;

    always_comb begin
        b_ext     = ADDR_W'(bfly);
        span      = ADDR_W'(1) << stage;
        pos       = b_ext & (span - ADDR_W'(1));
        grp       = b_ext >> stage;
        grp_shift = {1'b0, stage} + (STAGE_W+1)'(1);
        top_a     = (grp << grp_shift) | pos;
        bot_a     = top_a | span;
        tw_shift  = STAGE_W'(N_STAGES - 1) - stage;
        tw_wide   = pos << tw_shift;
        tw_idx    = tw_wide[BFLY_W-1:0];
    end

endmodule

// File: rtl/fft16_twiddle_rom.sv
// Constant table of W16^k = cos(2*pi*k/16) - j*sin(2*pi*k/16), Q1.15.
module fft16_twiddle_rom
    import fft16_pkg::*;
(
    input  logic [BFLY_W-1:0]      k,
    output logic signed [TW_W-1:0] w_re,
    output logic signed [TW_W-1:0] w_im
);

    always_comb begin
        unique case (k)
            3'd0: begin w_re =  16'sd32767; w_im =  16'sd0;     end
            3'd1: begin w_re =  16'sd30274; w_im = -16'sd12540; end
            3'd2: begin w_re =  16'sd23170; w_im = -16'sd23170; end
            3'd3: begin w_re =  16'sd12540; w_im = -16'sd30274; end
            3'd4: begin w_re =  16'sd0;     w_im = -16'sd32767; end
            3'd5: begin w_re = -16'sd12540; w_im = -16'sd30274; end
            3'd6: begin w_re = -16'sd23170; w_im = -16'sd23170; end
            3'd7: begin w_re = -16'sd30274; w_im = -16'sd12540; end
            default: begin w_re = '0; w_im = '0; end
        endcase
    end

endmodule

// File: rtl/fft16_round_sat.sv
// Drops SHIFT low bits with round-half-to-even, then clips to OW bits.
module fft16_round_sat #(
    parameter int SW    = 34,
    parameter int SHIFT = 16,
    parameter int OW    = 16
) (
    input  logic signed [SW-1:0] x,
    output logic signed [OW-1:0] y
);

    localparam int QW = SW - SHIFT;
    localparam logic [SHIFT-1:0] HALF = {1'b1, {(SHIFT-1){1'b0}}};
    localparam logic signed [OW-1:0] MAXV = {1'b0, {(OW-1){1'b1}}};
    localparam logic signed [OW-1:0] MINV = {1'b1, {(OW-1){1'b0}}};

    logic signed [QW-1:0] q;
    logic signed [QW-1:0] qr;
    logic [SHIFT-1:0]     rem;
    logic                 up;
    logic [QW-OW:0]       hi;
    logic                 ovf;

    always_comb begin
        q   = x[SW-1:SHIFT];
        rem = x[SHIFT-1:0];
        up  = (rem > HALF) || ((rem == HALF) && q[0]);
        qr  = q + QW'(up);
        hi  = qr[QW-1:OW-1];
        ovf = !((&hi) || (~|hi));
        if (ovf) begin
            y = qr[QW-1] ? MINV : MAXV;
        end else begin
            y = qr[OW-1:0];
        end
    end

endmodule

// File: rtl/fft16_butterfly.sv
// Scaled radix-2 butterfly: x = (a + b*w)/2, y = (a - b*w)/2.
module fft16_butterfly
    import fft16_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int TW = TW_W
) (
    input  logic signed [DW-1:0] a_re,
    input  logic signed [DW-1:0] a_im,
    input  logic signed [DW-1:0] b_re,
    input  logic signed [DW-1:0] b_im,
    input  logic signed [TW-1:0] w_re,
    input  logic signed [TW-1:0] w_im,
    output logic signed [DW-1:0] x_re,
    output logic signed [DW-1:0] x_im,
    output logic signed [DW-1:0] y_re,
    output logic signed [DW-1:0] y_im
);

    localparam int PW = DW + TW;
    localparam int SW = PW + 2;
    localparam int NOUT = 4;

    logic signed [PW-1:0] p_rr, p_ii, p_ri, p_ir;
    logic signed [SW-1:0] t_re, t_im;
    logic signed [SW-1:0] a_re_sh, a_im_sh;
    logic signed [SW-1:0] sums [NOUT];
    logic signed [DW-1:0] outs [NOUT];

    always_comb begin
        p_rr    = PW'(b_re) * PW'(w_re);
        p_ii    = PW'(b_im) * PW'(w_im);
        p_ri    = PW'(b_re) * PW'(w_im);
        p_ir    = PW'(b_im) * PW'(w_re);
        t_re    = SW'(p_rr) - SW'(p_ii);
        t_im    = SW'(p_ri) + SW'(p_ir);
        a_re_sh = SW'(a_re) <<< (TW - 1);
        a_im_sh = SW'(a_im) <<< (TW - 1);
        sums[0] = a_re_sh + t_re;
        sums[1] = a_im_sh + t_im;
        sums[2] = a_re_sh - t_re;
        sums[3] = a_im_sh - t_im;
    end

    for (genvar g = 0; g < NOUT; g++) begin : g_rnd
        fft16_round_sat #(
            .SW    (SW),
            .SHIFT (TW),
            .OW    (DW)
        ) u_rnd (
            .x (sums[g]),
            .y (outs[g])
        );
    end

    assign x_re = outs[0];
    assign x_im = outs[1];
    assign y_re = outs[2];
    assign y_im = outs[3];

endmodule

// File: rtl/fft16_data_mem.sv
// Sixteen complex registers: one load port, one butterfly pair write,
// three combinational read ports.
module fft16_data_mem
    import fft16_pkg::*;
#(
    parameter int DW    = DATA_W,
    parameter int DEPTH = N_PTS,
    parameter int AW    = ADDR_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ld_en,
    input  logic [AW-1:0]        ld_a,
    input  logic signed [DW-1:0] ld_re,
    input  logic signed [DW-1:0] ld_im,
    input  logic                 bf_en,
    input  logic [AW-1:0]        top_a,
    input  logic [AW-1:0]        bot_a,
    input  logic signed [DW-1:0] top_wre,
    input  logic signed [DW-1:0] top_wim,
    input  logic signed [DW-1:0] bot_wre,
    input  logic signed [DW-1:0] bot_wim,
    input  logic [AW-1:0]        out_a,
    output logic signed [DW-1:0] top_re,
    output logic signed [DW-1:0] top_im,
    output logic signed [DW-1:0] bot_re,
    output logic signed [DW-1:0] bot_im,
    output logic signed [DW-1:0] out_re,
    output logic signed [DW-1:0] out_im
);

    logic signed [DW-1:0] mem_re [DEPTH];
    logic signed [DW-1:0] mem_im [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_re[i] <= '0;
                mem_im[i] <= '0;
            end
        end else begin
            if (ld_en) begin
                mem_re[ld_a] <= ld_re;
                mem_im[ld_a] <= ld_im;
            end
            if (bf_en) begin
                mem_re[top_a] <= top_wre;
                mem_im[top_a] <= top_wim;
                mem_re[bot_a] <= bot_wre;
                mem_im[bot_a] <= bot_wim;
            end
        end
    end

    assign top_re = mem_re[top_a];
    assign top_im = mem_im[top_a];
    assign bot_re = mem_re[bot_a];
    assign bot_im = mem_im[bot_a];
    assign out_re = mem_re[out_a];
    assign out_im = mem_im[out_a];

endmodule

// File: rtl/fft16_core.sv
// Controller and datapath of the in-place 16-point FFT engine.
module fft16_core
    import fft16_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  logic signed [DATA_W-1:0] wr_re,
    input  logic signed [DATA_W-1:0] wr_im,
    input  logic                     start,
    input  logic [ADDR_W-1:0]        rd_addr,
    output logic signed [DATA_W-1:0] rd_re,
    output logic signed [DATA_W-1:0] rd_im,
    output logic                     busy,
    output logic                     done
);

    localparam int AW = ADDR_W;
    localparam int DW = DATA_W;
    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(N_STEPS - 1);

    fft_state_e          state_q, state_d;
    logic [STEP_W-1:0]   step_q;
    logic                last_step;
    logic                ld_en, bf_en;
    logic [AW-1:0]       wr_rev;
    logic [STAGE_W-1:0]  stage;
    logic [BFLY_W-1:0]   bfly;
    logic [AW-1:0]       top_a, bot_a;
    logic [BFLY_W-1:0]   tw_idx;
    logic signed [TW_W-1:0] w_re, w_im;
    logic signed [DW-1:0] a_re, a_im, b_re, b_im;
    logic signed [DW-1:0] x_re, x_im, y_re, y_im;

    // Sample index n is stored at its bit-reversed location.
    for (genvar b = 0; b < AW; b++) begin : g_rev
        assign wr_rev[b] = wr_addr[AW-1-b];
    end

    assign stage     = step_q[STEP_W-1:BFLY_W];
    assign bfly      = step_q[BFLY_W-1:0];
    assign last_step = (step_q == LAST_STEP);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic: launch, finish, retire
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start)     state_d = ST_CALC;
            ST_CALC: if (last_step) state_d = ST_DONE;
            ST_DONE:                state_d = ST_IDLE;
            default:                state_d = ST_IDLE;
        endcase
    end

    // Butterfly step counter: stage in the upper bits, butterfly below
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            step_q <= '0;
        end else if (state_q == ST_CALC) begin
            step_q <= step_q + STEP_W'(1);
        end else begin
            step_q <= '0;
        end
    end

    // Outputs and enables decoded from the state
    always_comb begin
        busy  = 1'b0;
        done  = 1'b0;
        ld_en = 1'b0;
        bf_en = 1'b0;
        unique case (state_q)
            ST_IDLE: ld_en = wr_en;
            ST_CALC: begin
                busy  = 1'b1;
                bf_en = 1'b1;
            end
            ST_DONE: done = 1'b1;
            default: ;
        endcase
    end

    fft16_addr_gen u_agen (
        .stage  (stage),
        .bfly   (bfly),
        .top_a  (top_a),
        .bot_a  (bot_a),
        .tw_idx (tw_idx)
    );

    fft16_twiddle_rom u_twid (
        .k    (tw_idx),
        .w_re (w_re),
        .w_im (w_im)
    );

    fft16_data_mem #(
        .DW    (DW),
        .DEPTH (N_PTS),
        .AW    (AW)
    ) u_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .ld_en   (ld_en),
        .ld_a    (wr_rev),
        .ld_re   (wr_re),
        .ld_im   (wr_im),
        .bf_en   (bf_en),
        .top_a   (top_a),
        .bot_a   (bot_a),
        .top_wre (x_re),
        .top_wim (x_im),
        .bot_wre (y_re),
        .bot_wim (y_im),
        .out_a   (rd_addr),
        .top_re  (a_re),
        .top_im  (a_im),
        .bot_re  (b_re),
        .bot_im  (b_im),
        .out_re  (rd_re),
        .out_im  (rd_im)
    );

    fft16_butterfly #(
        .DW (DW),
        .TW (TW_W)
    ) u_bfly (
        .a_re (a_re),
        .a_im (a_im),
        .b_re (b_re),
        .b_im (b_im),
        .w_re (w_re),
        .w_im (w_im),
        .x_re (x_re),
        .x_im (x_im),
        .y_re (y_re),
        .y_im (y_im)
    );

endmodule

// File: rtl/fft16_core_chk.sv
// Timing properties of the FFT engine's control handshake.
module fft16_core_chk
    import fft16_pkg::*;
(
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic busy,
    input logic done
);

    localparam int CW = STEP_W + 1;
    localparam logic [CW-1:0] LAST = CW'(N_STEPS - 1);

    logic [CW-1:0] busy_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_cnt <= '0;
        end else if (busy) begin
            busy_cnt <= busy_cnt + CW'(1);
        end else begin
            busy_cnt <= '0;
        end
    end

    // R3
    launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && !done) |=> busy);

    // R3
    busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && busy_cnt == LAST) |=> !busy);

    // R5
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && busy_cnt != LAST) |=> busy);

    // R4
    done_after_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    // R4
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    // R4
    no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |-> (!busy && !done));

endmodule

bind fft16_core fft16_core_chk u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .busy  (busy),
    .done  (done)
);

// File: tb/fft16_core_tb.sv
module fft16_core_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk;
    logic        rst_n;
    logic        wr_en;
    logic [3:0]  wr_addr;
    logic [15:0] wr_re, wr_im;
    logic        start;
    logic [3:0]  rd_addr;
    logic [15:0] rd_re, rd_im;
    logic        busy, done;

    int n_vec;
    int n_bad;
    int phase;
    int exp_re [16];
    int exp_im [16];
    int stim_re [16];
    int stim_im [16];
    int tw_re [8] = '{32767, 30274, 23170, 12540, 0, -12540, -23170, -30274};
    int tw_im [8] = '{0, -12540, -23170, -30274, -32767, -30274, -23170, -12540};
    int unsigned seed;

    fft16_core u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_re   (wr_re),
        .wr_im   (wr_im),
        .start   (start),
        .rd_addr (rd_addr),
        .rd_re   (rd_re),
        .rd_im   (rd_im),
        .busy    (busy),
        .done    (done)
    );

    initial begin
        clk = 1'b0;
        forever #(CLK_PERIOD/2) clk = ~clk;
    end

    function automatic int rev4(int a);
        return ((a & 1) << 3) | ((a & 2) << 1) | ((a & 4) >> 1) | ((a & 8) >> 3);
    endfunction

    // R9 R10: drop 16 bits, ties to even, clip to 16 bits
    function automatic int rnd_sat(longint v);
        longint q;
        longint r;
        q = v >>> 16;
        r = v - (q <<< 16);
        if (r > 32768 || (r == 32768 && q[0])) q = q + 1;
        if (q > 32767) q = 32767;
        if (q < -32768) q = -32768;
        return int'(q);
    endfunction

    // R7 R8: reference transform over the stored layout
    task automatic model_fft();
        for (int span = 1; span < 16; span = span * 2) begin
            for (int g = 0; g < 16; g = g + 2 * span) begin
                for (int p = 0; p < span; p++) begin
                    int t = g + p;
                    int b = t + span;
                    int k = p * (8 / span);
                    longint tr = longint'(exp_re[b]) * tw_re[k] - longint'(exp_im[b]) * tw_im[k];
                    longint ti = longint'(exp_re[b]) * tw_im[k] + longint'(exp_im[b]) * tw_re[k];
                    longint ar = longint'(exp_re[t]) * 32768;
                    longint ai = longint'(exp_im[t]) * 32768;
                    exp_re[t] = rnd_sat(ar + tr);
                    exp_im[t] = rnd_sat(ai + ti);
                    exp_re[b] = rnd_sat(ar - tr);
                    exp_im[b] = rnd_sat(ai - ti);
                end
            end
        end
    endtask

    // Cycle model: phase 0 idle, 1..32 busy, 33 done
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase = 0;
            for (int i = 0; i < 16; i++) begin
                exp_re[i] = 0;
                exp_im[i] = 0;
            end
        end else if (phase == 0) begin
            if (wr_en) begin
                exp_re[rev4(int'(wr_addr))] = int'($signed(wr_re));
                exp_im[rev4(int'(wr_addr))] = int'($signed(wr_im));
            end
            if (start) begin
                model_fft();
                phase = 1;
            end
        end else if (phase < 33) begin
            phase = phase + 1;
        end else begin
            phase = 0;
        end
    end

    task automatic chk(bit ok, string req, string what, int act, int expv);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            chk(busy == (phase >= 1 && phase <= 32), "R3", "busy", int'(busy),
                int'(phase >= 1 && phase <= 32));
            chk(done == (phase == 33), "R4", "done", int'(done), int'(phase == 33));
            if (phase == 0) begin
                chk(int'($signed(rd_re)) == exp_re[rd_addr], "R7", "rd_re",
                    int'($signed(rd_re)), exp_re[rd_addr]);
                chk(int'($signed(rd_im)) == exp_im[rd_addr], "R7", "rd_im",
                    int'($signed(rd_im)), exp_im[rd_addr]);
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic load_stim();
        for (int n = 0; n < 16; n++) begin
            wr_en   = 1'b1;
            wr_addr = 4'(n);
            wr_re   = 16'(stim_re[n]);
            wr_im   = 16'(stim_im[n]);
            tick();
        end
        wr_en = 1'b0;
    endtask

    // R11: combinational read, no clock between address and data
    task automatic read_all(string req);
        for (int k = 0; k < 16; k++) begin
            rd_addr = 4'(k);
            #1;
            chk(int'($signed(rd_re)) == exp_re[k], req, "bin re", int'($signed(rd_re)), exp_re[k]);
            chk(int'($signed(rd_im)) == exp_im[k], req, "bin im", int'($signed(rd_im)), exp_im[k]);
        end
    endtask

    // Runs a transform; optionally pokes start/wr_en while busy and in done
    task automatic run_fft(bit poke);
        int bcnt = 0;
        int dcnt = 0;
        start = 1'b1;
        tick();
        start = 1'b0;
        for (int c = 0; c < 40; c++) begin
            if (busy) bcnt++;
            if (done) begin
                dcnt++;
                if (poke) begin
                    start = 1'b1; wr_en = 1'b1; wr_addr = 4'd0;
                    wr_re = 16'h1357; wr_im = 16'h2468;
                end
            end else if (poke && c == 10) begin
                start = 1'b1; wr_en = 1'b1; wr_addr = 4'd3;
                wr_re = 16'h0bad; wr_im = 16'h0bad;
            end
            tick();
            start = 1'b0;
            wr_en = 1'b0;
        end
        chk(bcnt == 32, "R3", "busy cycles", bcnt, 32);
        chk(dcnt == 1, "R4", "done cycles", dcnt, 1);
    endtask

    function automatic int lcg16();
        seed = seed * 32'd1103515245 + 32'd12345;
        return int'($signed(seed[31:16]));
    endfunction

    initial begin
        #(CLK_PERIOD * 150000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        n_vec = 0; n_bad = 0; seed = 32'd2024;
        rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_re = '0; wr_im = '0;
        start = 1'b0; rd_addr = '0;
        #(CLK_PERIOD * 2 + 3);
        // R1: reset state
        chk(busy == 1'b0, "R1", "busy in reset", int'(busy), 0);
        chk(done == 1'b0, "R1", "done in reset", int'(done), 0);
        for (int k = 0; k < 16; k++) begin
            rd_addr = 4'(k);
            #1;
            chk(rd_re == 16'd0 && rd_im == 16'd0, "R1", "location in reset",
                int'($signed(rd_re)), 0);
        end
        @(negedge clk);
        rst_n = 1'b1;
        tick();
        read_all("R1");

        // R2 R7: impulse, exact scaled spectrum
        for (int n = 0; n < 16; n++) begin stim_re[n] = 0; stim_im[n] = 0; end
        stim_re[0] = 16384; stim_im[0] = -16384;
        load_stim();
        read_all("R2/R11");
        chk(int'($signed(rd_re)) == 0 && exp_re[15] == 0, "R2", "bit-reversed slot 15", int'($signed(rd_re)), 0);
        rd_addr = 4'd0; #1;
        chk(int'($signed(rd_re)) == 16384, "R2", "sample 0 at slot 0", int'($signed(rd_re)), 16384);
        run_fft(1'b0);
        for (int k = 0; k < 16; k++) begin
            rd_addr = 4'(k); #1;
            chk(int'($signed(rd_re)) == 1024, "R7", "impulse bin re", int'($signed(rd_re)), 1024);
            chk(int'($signed(rd_im)) == -1024, "R7", "impulse bin im", int'($signed(rd_im)), -1024);
        end

        // R2: write of sample 1 lands at slot 8
        stim_re[1] = 777; wr_en = 1'b1; wr_addr = 4'd1; wr_re = 16'd777; wr_im = 16'd0;
        tick(); wr_en = 1'b0;
        rd_addr = 4'd8; #1;
        chk(int'($signed(rd_re)) == 777, "R2", "sample 1 at slot 8", int'($signed(rd_re)), 777);

        // R7: constant input gives energy only in bin 0
        for (int n = 0; n < 16; n++) begin stim_re[n] = 8000; stim_im[n] = -8000; end
        load_stim();
        run_fft(1'b0);
        rd_addr = 4'd0; #1;
        chk(int'($signed(rd_re)) == 8000, "R7", "dc bin0 re", int'($signed(rd_re)), 8000);
        chk(int'($signed(rd_im)) == -8000, "R7", "dc bin0 im", int'($signed(rd_im)), -8000);
        rd_addr = 4'd9; #1;
        chk(int'($signed(rd_re)) == 0, "R7", "dc bin9 re", int'($signed(rd_re)), 0);

        // R9: halves that tie must go to even, giving zero everywhere
        for (int n = 0; n < 16; n++) begin stim_re[n] = 0; stim_im[n] = 0; end
        stim_re[0] = 3; stim_im[0] = -3;
        load_stim();
        run_fft(1'b0);
        rd_addr = 4'd0; #1;
        chk(int'($signed(rd_re)) == 0, "R9", "tie bin0 re", int'($signed(rd_re)), 0);
        chk(int'($signed(rd_im)) == 0, "R9", "tie bin0 im", int'($signed(rd_im)), 0);
        read_all("R9");

        // R10: pattern that overflows at the 45-degree twiddle
        for (int p = 0; p < 16; p++) begin stim_re[rev4(p)] = 0; stim_im[rev4(p)] = 0; end
        for (int h = 0; h < 2; h++) begin
            stim_re[rev4(4*h+0)] =  32767; stim_im[rev4(4*h+0)] =  32767;
            stim_re[rev4(4*h+1)] = -32767; stim_im[rev4(4*h+1)] = -32767;
            stim_re[rev4(4*h+2)] = -32767; stim_im[rev4(4*h+2)] =  32767;
            stim_re[rev4(4*h+3)] =  32767; stim_im[rev4(4*h+3)] = -32767;
        end
        load_stim();
        run_fft(1'b0);
        read_all("R10");

        // R7 R8 R12-free random runs, half scale and full scale
        for (int r = 0; r < 6; r++) begin
            for (int n = 0; n < 16; n++) begin
                stim_re[n] = (r < 3) ? lcg16() / 2 : lcg16();
                stim_im[n] = (r < 3) ? lcg16() / 2 : lcg16();
            end
            load_stim();
            run_fft(1'b0);
            read_all("R7/R8");
        end

        // R5 R6: start and writes during busy and done are ignored
        for (int n = 0; n < 16; n++) begin stim_re[n] = lcg16(); stim_im[n] = lcg16(); end
        load_stim();
        run_fft(1'b1);
        chk(busy == 1'b0, "R5", "idle after poked run", int'(busy), 0);
        read_all("R5/R6");
        rd_addr = 4'd12; #1;
        chk(int'($signed(rd_re)) == exp_re[12], "R6", "slot 12 after busy write", int'($signed(rd_re)), exp_re[12]);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule